// File: doc/BRIEF.md
# Byte-Register SPI Master with Multi-Length Frames

This block is an SPI master that a host controls through six byte-wide registers on a simple address/strobe bus. One control byte sets the clock polarity, the clock phase, the frame length, the slave-select mode and the target slave. A second byte, called the status byte, holds the shift order, the SCLK rate and an interrupt enable, and it reports a busy flag. Four data bytes form one 32-bit shift word.

A frame is 8, 16, 24 or 32 bits long and always occupies the upper bytes of that word. The host fills the data bytes. In automatic mode, writing the highest data byte both asserts the chosen slave select and starts the frame. The host then polls the busy flag. When the frame ends, the received bits replace the frame bytes in place.

The block divides its system clock by an even half-period count to make SCLK. The counter restarts at the start of each frame. A single enable bit gates an interrupt request that the slaves drive toward the master.

Top module: `spi_regbus_master`

## Requirements
- R1: Control bits [5:4] select the frame length: 00 gives 8 bits, 01 gives 16, 10 gives 24 and 11 gives 32. The frame uses the most significant bytes of the word {byte3,byte2,byte1,byte0}. Bytes 0 to 3 sit at addresses 2 to 5, control at address 0 and status at address 1.
- R2: With status bit 2 at 0, MOSI sends word bit 31 first and moves toward lower bits. The i-th bit received (counting from 0) lands at word bit 31-i.
- R3: With status bit 2 at 1, MOSI sends word bit 32-N first (N is the frame length) and moves toward higher bits. The i-th bit received lands at word bit 32-N+i.
- R4: A write to address 5 while idle starts a frame. Status bit 0 reads 1 from the next cycle until the frame completes. When it falls, the frame bytes hold the received data and the bytes below the frame are unchanged.
- R5: Control bit 7 sets the SCLK idle level. With control bit 6 at 0, MISO is sampled and the slave sees MOSI stable on the leading edge. With bit 6 at 1, both happen on the trailing edge. Each frame has exactly 2N SCLK edges.
- R6: Status bits [5:4] set the SCLK half period to 16, 8, 4 or 2 system clocks for codes 0 to 3. At a 32 MHz system clock this gives 1, 2, 4 or 8 MHz.
- R7: In automatic mode (control bit 3 = 0), only the slave-select line chosen by control bits [2:0] goes low. It goes low one half period before the first SCLK edge and returns high one half period after the last edge. All lines stay high while idle.
- R8: With control bit 3 at 1, the chosen slave-select line is held low for as long as the bit stays set. Clearing the bit raises it again.
- R9: While status bit 0 is 1, writes to the control, status and data registers have no effect, and a write to address 5 starts no second frame.
- R10: The interrupt output equals status bit 1 AND the slave interrupt input.
- R11: After reset, all registers read 0, every slave-select line is high, SCLK is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Serial data from the slaves |
| ss_n | output | NUM_SS | Slave selects, active low |
| slave_irq | input | 1 | Interrupt request from the slaves |
| irq | output | 1 | Gated interrupt toward the system |

## Verification
The bench acts as an SPI slave. It records the MOSI bits at the sampling edge and drives MISO from a random reply on the shifting edge. This lets it compare the transmitted order, the placement of the received bits and the untouched low bytes against its own model.

Random frames mix all four lengths, both bit orders, all four clock modes, all four rates and all slave numbers. A wrong byte-window offset, a reversed shift or an edge on the wrong phase each show up as a different mismatch.

Directed cases cover the following:
- the 32-bit frame in both orders, where no byte is preserved;
- the 8-bit frame, where three bytes must survive;
- register writes during a busy frame;
- manual slave select;
- interrupt gating.

Measured half periods and the select-to-edge spacing separate the divider codes.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int WORD_BITS  = 32;
  localparam int BYTE_BITS  = 8;
  localparam int NUM_BYTES  = WORD_BITS / BYTE_BITS;
  localparam int RATE_CODES = 4;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_DATA  = 2;

  typedef logic [WORD_BITS-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN,
    ST_TAIL,
    ST_WB
  } seq_state_t;

  // number of bits in a frame for a length code
  function automatic int frame_bits(input logic [1:0] len);
    return BYTE_BITS * (int'(len) + 1);
  endfunction

  // SCLK half period in system clocks for a rate code
  function automatic int half_cycles(input logic [1:0] rate, input int base);
    return base << (RATE_CODES - 1 - int'(rate));
  endfunction

  function automatic word_t frame_mask(input int nb);
    if (nb >= WORD_BITS) return '1;
    return (word_t'(1) << nb) - word_t'(1);
  endfunction

  // frame bits moved down to the low end
  function automatic word_t extract_frame(input word_t w, input logic [1:0] len);
    int nb;
    nb = frame_bits(len);
    return (w >> (WORD_BITS - nb)) & frame_mask(nb);
  endfunction

  // one shift step: the received bit enters at the far end
  function automatic word_t step_frame(input word_t fr, input logic b,
                                       input logic [1:0] len, input logic lsb);
    int nb;
    nb = frame_bits(len);
    if (lsb) return ((fr >> 1) | (word_t'(b) << (nb - 1))) & frame_mask(nb);
    return ((fr << 1) | word_t'(b)) & frame_mask(nb);
  endfunction

  function automatic logic out_bit(input word_t fr, input logic [1:0] len, input logic lsb);
    int nb;
    nb = frame_bits(len);
    return lsb ? fr[0] : fr[nb-1];
  endfunction

  // received frame placed back over the top bytes of the word
  function automatic word_t merge_frame(input word_t w, input word_t fr, input logic [1:0] len);
    int nb;
    int sh;
    nb = frame_bits(len);
    sh = WORD_BITS - nb;
    return (fr << sh) | (w & ~(frame_mask(nb) << sh));
  endfunction
endpackage

// File: rtl/spi_rb_regs.sv
module spi_rb_regs
  import spi_rb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       busy,
  input  logic       wb,
  input  word_t      rx_frame,
  output logic       cpol,
  output logic       cpha,
  output logic [1:0] len,
  output logic       manual,
  output logic [2:0] sel,
  output logic       irq_en,
  output logic       lsb_first,
  output logic [1:0] rate,
  output word_t      word,
  output logic       start,
  output word_t      start_word
);
  localparam logic [2:0] A_CTRL = 3'(ADDR_CTRL);
  localparam logic [2:0] A_STAT = 3'(ADDR_STAT);
  localparam logic [2:0] A_TOP  = 3'(ADDR_DATA + NUM_BYTES - 1);

  logic [7:0] ctrl_q;
  logic       irq_en_q;
  logic       lsb_q;
  logic [1:0] rate_q;
  logic [7:0] data_q [NUM_BYTES];
  logic       wr_ok;
  word_t      merged;

  assign wr_ok = bus_wr && !busy;
  assign start = wr_ok && (bus_addr == A_TOP);
  assign merged = merge_frame(word, rx_frame, len);
  assign start_word = {bus_wdata, word[WORD_BITS-BYTE_BITS-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      irq_en_q <= 1'b0;
      lsb_q    <= 1'b0;
      rate_q   <= '0;
    end else if (wr_ok) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata;
      if (bus_addr == A_STAT) begin
        irq_en_q <= bus_wdata[1];
        lsb_q    <= bus_wdata[2];
        rate_q   <= bus_wdata[5:4];
      end
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    localparam logic [2:0] A_BYTE = 3'(ADDR_DATA + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        data_q[g] <= '0;
      else if (wb)
        data_q[g] <= merged[g*BYTE_BITS +: BYTE_BITS];
      else if (wr_ok && bus_addr == A_BYTE)
        data_q[g] <= bus_wdata;
    end
    assign word[g*BYTE_BITS +: BYTE_BITS] = data_q[g];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0: bus_rdata = ctrl_q;
      3'd1: bus_rdata = {2'b00, rate_q, 1'b0, lsb_q, irq_en_q, busy};
      3'd2: bus_rdata = data_q[0];
      3'd3: bus_rdata = data_q[1];
      3'd4: bus_rdata = data_q[2];
      3'd5: bus_rdata = data_q[3];
      default: bus_rdata = '0;
    endcase
  end

  assign cpol      = ctrl_q[7];
  assign cpha      = ctrl_q[6];
  assign len       = ctrl_q[5:4];
  assign manual    = ctrl_q[3];
  assign sel       = ctrl_q[2:0];
  assign irq_en    = irq_en_q;
  assign lsb_first = lsb_q;
  assign rate      = rate_q;
endmodule

// File: rtl/spi_rb_seq.sv
module spi_rb_seq
  import spi_rb_pkg::*;
#(
  parameter int BASE_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] rate,
  input  logic [1:0] len,
  output logic       busy,
  output logic       ss_active,
  output logic       sclk_phase,
  output logic       edge_now,
  output logic       lead_now,
  output logic       trail_now,
  output logic       first_edge,
  output logic       finish,
  output logic       wb
);
  localparam int MAX_HALF = BASE_HALF << (RATE_CODES - 1);
  localparam int CNT_W    = $clog2(MAX_HALF + 1);
  localparam int EDGE_W   = $clog2(2 * WORD_BITS + 1);

  seq_state_t        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  half_m1;
  logic [EDGE_W-1:0] k_q;
  logic [EDGE_W-1:0] last_k;
  logic              phase_q;
  logic              in_shift;

  assign half_m1    = CNT_W'(half_cycles(rate, BASE_HALF) - 1);
  assign last_k     = EDGE_W'(2 * frame_bits(len) - 1);
  assign in_shift   = (st_q == ST_LEAD) || (st_q == ST_RUN);
  assign edge_now   = in_shift && (cnt_q == '0);
  assign lead_now   = edge_now && !k_q[0];
  assign trail_now  = edge_now && k_q[0];
  assign first_edge = (k_q == '0);
  assign finish     = (st_q == ST_TAIL) && (cnt_q == '0);
  assign wb         = (st_q == ST_WB);
  assign busy       = (st_q != ST_IDLE);
  assign ss_active  = in_shift || (st_q == ST_TAIL);
  assign sclk_phase = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      k_q     <= '0;
      phase_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_LEAD;
          cnt_q   <= half_m1;
          k_q     <= '0;
          phase_q <= 1'b0;
        end
        ST_LEAD, ST_RUN: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            phase_q <= ~phase_q;
            cnt_q   <= half_m1;
            k_q     <= k_q + EDGE_W'(1);
            st_q    <= (k_q == last_k) ? ST_TAIL : ST_RUN;
          end
        end
        ST_TAIL: begin
          if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
          else             st_q  <= ST_WB;
        end
        ST_WB:   st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_rb_shift.sv
module spi_rb_shift
  import spi_rb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  word_t      start_word,
  input  logic [1:0] len,
  input  logic       lsb_first,
  input  logic       cpha,
  input  logic       miso,
  input  logic       lead_now,
  input  logic       trail_now,
  input  logic       first_edge,
  input  logic       finish,
  output logic       mosi,
  output word_t      frame
);
  word_t fr_q;
  logic  rx_q;
  logic  sample_evt;
  logic  shift_evt;

  // phase 0: sample on leading, shift on trailing
  // phase 1: sample on trailing, shift on later leading edges and once after the last edge
  assign sample_evt = cpha ? trail_now : lead_now;
  assign shift_evt  = cpha ? ((lead_now && !first_edge) || finish) : trail_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= '0;
      rx_q <= 1'b0;
    end else begin
      if (start)      fr_q <= extract_frame(start_word, len);
      else if (shift_evt) fr_q <= step_frame(fr_q, rx_q, len, lsb_first);
      if (sample_evt) rx_q <= miso;
    end
  end

  assign mosi  = out_bit(fr_q, len, lsb_first);
  assign frame = fr_q;
endmodule

// File: rtl/spi_regbus_master.sv
module spi_regbus_master
  import spi_rb_pkg::*;
#(
  parameter int NUM_SS    = 8,
  parameter int BASE_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n,
  input  logic              slave_irq,
  output logic              irq
);
  logic       cpol_w, cpha_w, manual_w, irq_en_w, lsb_w;
  logic [1:0] len_w, rate_w;
  logic [2:0] sel_w;
  word_t      word_w, start_word_w, frame_w;
  logic       start_w, busy_w, ss_act_w, phase_w;
  logic       edge_w, lead_w, trail_w, first_w, finish_w, wb_w;

  spi_rb_regs i_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .wb(wb_w), .rx_frame(frame_w),
    .cpol(cpol_w), .cpha(cpha_w), .len(len_w), .manual(manual_w), .sel(sel_w),
    .irq_en(irq_en_w), .lsb_first(lsb_w), .rate(rate_w),
    .word(word_w), .start(start_w), .start_word(start_word_w)
  );

  spi_rb_seq #(.BASE_HALF(BASE_HALF)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start_w), .rate(rate_w), .len(len_w),
    .busy(busy_w), .ss_active(ss_act_w), .sclk_phase(phase_w),
    .edge_now(edge_w), .lead_now(lead_w), .trail_now(trail_w),
    .first_edge(first_w), .finish(finish_w), .wb(wb_w)
  );

  spi_rb_shift i_shift (
    .clk(clk), .rst_n(rst_n), .start(start_w), .start_word(start_word_w),
    .len(len_w), .lsb_first(lsb_w), .cpha(cpha_w), .miso(miso),
    .lead_now(lead_w), .trail_now(trail_w), .first_edge(first_w), .finish(finish_w),
    .mosi(mosi), .frame(frame_w)
  );

  assign sclk = phase_w ^ cpol_w;
  assign irq  = irq_en_w && slave_irq;

  for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
    assign ss_n[g] = !((sel_w == 3'(g)) && (manual_w || ss_act_w));
  end
endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk
  import spi_rb_pkg::*;
#(
  parameter int NUM_SS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wb,
  input logic              start,
  input logic              edge_now,
  input logic              sclk,
  input logic [NUM_SS-1:0] ss_n,
  input logic              manual,
  input word_t             word
);
  AST_SS_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n)); // R7
  AST_AUTO_SS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual && !busy) |-> (&ss_n)); // R7
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R4
  AST_IDLE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    wb |=> !busy); // R4
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wb) |=> $stable(word)); // R9
  AST_SCLK_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !edge_now) |=> $stable(sclk)); // R6
endmodule

bind spi_regbus_master spi_rb_chk #(.NUM_SS(NUM_SS)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .wb(wb_w), .start(start_w),
  .edge_now(edge_w), .sclk(sclk), .ss_n(ss_n), .manual(manual_w), .word(word_w)
);

// File: tb/test_spi_regbus_master.sv
`timescale 1ns/1ps
module test_spi_regbus_master;
  localparam int NSS = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     bus_addr = '0;
  logic           bus_wr = 1'b0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic           sclk, mosi;
  logic           miso_r = 1'b0;
  logic [NSS-1:0] ss_n;
  logic           slave_irq = 1'b0;
  logic           irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_regbus_master #(.NUM_SS(NSS), .BASE_HALF(2)) i_spi_regbus_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso_r), .ss_n(ss_n), .slave_irq(slave_irq), .irq(irq)
  );

  // slave model state
  logic        m_cpha = 1'b0;
  logic [31:0] m_reply = '0;
  logic [31:0] tx_cap;
  int          n_samp, n_edges, bad_gaps, lead_gap, tail_gap, m_half;
  int          cyc = 0, ss_fall_cyc = 0, last_edge_cyc = 0, jb = 0;
  logic [NSS-1:0] low_mask;
  logic        prev_sclk = 1'b0;
  logic        prev_all_high = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_all_high && !(&ss_n)) begin
        ss_fall_cyc = cyc; n_edges = 0; n_samp = 0; tx_cap = '0; low_mask = '0;
        bad_gaps = 0; jb = 0;
        if (!m_cpha) begin miso_r = m_reply[0]; jb = 1; end
      end
      if (!(&ss_n)) low_mask = low_mask | ~ss_n;
      if (sclk != prev_sclk) begin
        if (n_edges == 0) lead_gap = cyc - ss_fall_cyc;
        else if (cyc - last_edge_cyc != m_half) bad_gaps++;
        last_edge_cyc = cyc;
        if ((n_edges % 2 == 0) != m_cpha) begin
          if (n_samp < 32) tx_cap[n_samp] = mosi;
          n_samp++;
        end
        if ((n_edges % 2 == 1) != m_cpha) begin
          if (jb < 32) miso_r = m_reply[jb];
          jb++;
        end
        n_edges++;
      end
      if (!prev_all_high && (&ss_n)) tail_gap = cyc - last_edge_cyc;
    end
    prev_sclk = sclk;
    prev_all_high = &ss_n;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int exp_bits(input logic [1:0] len);
    return 8 * int'(len) + 8;
  endfunction

  function automatic int exp_half(input logic [1:0] rate);
    return 16 >> rate;
  endfunction

  function automatic logic [31:0] exp_tx(input logic [31:0] w, input int nb, input logic lsb);
    logic [31:0] r = '0;
    for (int i = 0; i < nb; i++) r[i] = lsb ? w[32-nb+i] : w[31-i];
    return r;
  endfunction

  function automatic logic [31:0] exp_result(input logic [31:0] w, input logic [31:0] rep,
                                             input int nb, input logic lsb);
    logic [31:0] r = w;
    for (int i = 0; i < nb; i++) begin
      if (lsb) r[32-nb+i] = rep[i];
      else     r[31-i]    = rep[i];
    end
    return r;
  endfunction

  task automatic run_xfer(input logic cpol, input logic cpha, input logic [1:0] len,
                          input logic lsb, input logic [1:0] rate, input logic [2:0] sel,
                          input logic [31:0] w, input logic [31:0] rep, input bit poke);
    logic [7:0] ctrl, stat, d, b0, b1, b2, b3;
    int nb, waited;
    logic [31:0] got, expw;
    ctrl = {cpol, cpha, len, 1'b0, sel};
    stat = {2'b00, rate, 1'b0, lsb, 1'b0, 1'b0};
    nb = exp_bits(len);
    m_cpha = cpha; m_reply = rep; m_half = exp_half(rate);
    bus_write(3'd0, ctrl);
    bus_write(3'd1, stat);
    bus_write(3'd2, w[7:0]);
    bus_write(3'd3, w[15:8]);
    bus_write(3'd4, w[23:16]);
    bus_write(3'd5, w[31:24]);
    bus_read(3'd1, d);
    check(d[0] == 1'b1, "R4 busy after start", {24'd0, d}, {24'd0, stat | 8'h01});
    if (poke) begin
      bus_write(3'd0, ctrl ^ 8'h5B);
      bus_write(3'd1, ~stat);
      bus_write(3'd2, 8'hC3);
      bus_write(3'd5, 8'h3C);
    end
    waited = 0;
    do begin
      bus_read(3'd1, d);
      waited++;
    end while (d[0] && waited < 4000);
    check(!d[0], "R4 busy clears", {31'd0, d[0]}, 32'd0);
    repeat (4) @(negedge clk);
    bus_read(3'd2, b0); bus_read(3'd3, b1); bus_read(3'd4, b2); bus_read(3'd5, b3);
    got = {b3, b2, b1, b0};
    expw = exp_result(w, rep, nb, lsb);
    check(got == expw, lsb ? "R3 R1 R4 received word" : "R2 R1 R4 received word", got, expw);
    check(n_samp == nb && tx_cap == exp_tx(w, nb, lsb),
          lsb ? "R3 R5 transmitted bits" : "R2 R5 transmitted bits", tx_cap, exp_tx(w, nb, lsb));
    check(n_edges == 2 * nb, "R5 edge count", n_edges, 2 * nb);
    check(bad_gaps == 0, "R6 half period", bad_gaps, 0);
    check(lead_gap == m_half && tail_gap == m_half, "R7 select lead and tail",
          {lead_gap[15:0], tail_gap[15:0]}, {m_half[15:0], m_half[15:0]});
    check(low_mask == NSS'(1) << sel, "R7 selected line", {24'd0, low_mask}, {24'd0, 8'(1) << sel});
    @(negedge clk);
    check(sclk == cpol && (&ss_n), "R5 R7 idle levels", {30'd0, sclk, &ss_n}, {30'd0, cpol, 1'b1});
    if (poke) begin
      bus_read(3'd0, d);
      check(d == ctrl, "R9 control kept", {24'd0, d}, {24'd0, ctrl});
      bus_read(3'd1, d);
      check(d == stat, "R9 status kept", {24'd0, d}, {24'd0, stat});
      check(n_edges == 2 * nb, "R9 no second frame", n_edges, 2 * nb);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h0000_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    @(negedge clk);
    check((&ss_n) && !sclk && !irq, "R11 pins after reset", {29'd0, &ss_n, sclk, irq}, 32'h4);
    bus_read(3'd0, d); check(d == 8'h00, "R11 control reset", {24'd0, d}, 32'd0);
    bus_read(3'd1, d); check(d == 8'h00, "R11 status reset", {24'd0, d}, 32'd0);
    bus_read(3'd5, d); check(d == 8'h00, "R11 data reset", {24'd0, d}, 32'd0);

    // R10 interrupt gating
    slave_irq = 1'b1; @(negedge clk);
    check(!irq, "R10 disabled", {31'd0, irq}, 32'd0);
    bus_write(3'd1, 8'h02); @(negedge clk);
    check(irq, "R10 enabled", {31'd0, irq}, 32'd1);
    slave_irq = 1'b0; @(negedge clk);
    check(!irq, "R10 input low", {31'd0, irq}, 32'd0);

    // R8 manual select
    bus_write(3'd0, 8'h0A); @(negedge clk);
    check(ss_n == ~8'h04, "R8 manual assert", {24'd0, ss_n}, {24'd0, ~8'h04});
    bus_write(3'd0, 8'h02); @(negedge clk);
    check(&ss_n, "R8 manual release", {24'd0, ss_n}, 32'hFF);
    bus_write(3'd0, 8'h80); @(negedge clk);
    check(sclk == 1'b1, "R5 idle high with polarity 1", {31'd0, sclk}, 32'd1);

    // directed corners
    run_xfer(1'b0, 1'b0, 2'b10, 1'b0, 2'd3, 3'd6, 32'h40_0A_44_99, 32'h00A5_5A3C, 0);
    run_xfer(1'b0, 1'b0, 2'b11, 1'b0, 2'd2, 3'd0, 32'hDEAD_BEEF, 32'h1234_5678, 0);
    run_xfer(1'b1, 1'b1, 2'b11, 1'b1, 2'd1, 3'd7, 32'hCAFE_F00D, 32'h8765_4321, 0);
    run_xfer(1'b0, 1'b1, 2'b00, 1'b1, 2'd0, 3'd3, 32'h81_22_33_44, 32'h0000_0096, 0);
    run_xfer(1'b1, 1'b0, 2'b00, 1'b0, 2'd0, 3'd1, 32'h5A_11_22_33, 32'h0000_00C3, 1);
    run_xfer(1'b0, 1'b0, 2'b01, 1'b1, 2'd3, 3'd5, 32'hF0F0_1357, 32'h0000_6E21, 0);

    // constrained random frames
    for (int n = 0; n < 24; n++) begin
      run_xfer(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
               3'($urandom), $urandom, $urandom, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule